// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This execution unit multiplies the low 32 bits of two 64-bit source operands and adds the product to a 64-bit accumulator. The operands and the addition are treated as signed or unsigned under one control bit. A second control bit turns on saturation. Signed saturation clamps the result to the 32-bit two's-complement range. Unsigned saturation clamps only at the 64-bit ceiling. The accumulated value is written into both the low and the high result registers, and a third control bit picks which of them is copied to the destination write-data port.

Issue is legal only in the 64-bit mode or the 32-bit kernel mode. An issue in either of the other two 32-bit modes raises a one-cycle reserved-operation flag and changes nothing. An accepted issue keeps the unit busy for one cycle. On the next cycle a one-cycle done pulse appears together with the new results. The unit can accept a new issue in the done cycle, and that issue accumulates onto the value just written, with no stall cycles.

Top module: `mac_sat_unit`

## Requirements
- R1: Only bits [31:0] of `rs_i` and `rt_i` are used. With `us_i`=1 they are multiplied as unsigned values. With `us_i`=0 they are multiplied as two's-complement values. The product is added to the current accumulator, which is sign-extended when `us_i`=0 and zero-extended when `us_i`=1.
- R2: On completion, `lo_o` and `hi_o` both take the new 64-bit accumulator value. `rd_o` takes the new `hi_o` value when `hi_i`=1 and the new `lo_o` value when `hi_i`=0.
- R3: With `sat_i`=0 the low 64 bits of the exact sum are stored and the sum wraps on overflow. This holds for both values of `us_i`.
- R4: With `us_i`=0 and `sat_i`=1, a sum above 2^31-1 stores 0x0000_0000_7FFF_FFFF.
- R5: With `us_i`=0 and `sat_i`=1, a sum below -2^31 stores 0xFFFF_FFFF_8000_0000.
- R6: With `us_i`=1 and `sat_i`=1, a sum at or above 2^64 stores 0xFFFF_FFFF_FFFF_FFFF. There is no lower bound.
- R7: `mode_i` is encoded as 0 = 32-bit user, 1 = 32-bit supervisor, 2 = 32-bit kernel and 3 = 64-bit. An issue in mode 0 or 1 sets `rsvd_o` for the next cycle only. Such an issue does not raise `busy_o` or `done_o`, and it leaves `lo_o`, `hi_o` and `rd_o` unchanged.
- R8: When `busy_o` is low, a legal `start_i` is accepted. `busy_o` is then high for exactly the next cycle. `done_o` is high for the cycle after that, with the results already visible on the outputs. A `start_i` seen while `busy_o` is high is ignored.
- R9: A legal `start_i` presented in the cycle where `done_o` is high is accepted. It accumulates onto the value that completed in that cycle.
- R10: After reset, `lo_o`, `hi_o` and `rd_o` are zero, and `busy_o`, `done_o` and `rsvd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue strobe |
| mode_i | input | 2 | Processor mode (0 user32, 1 supervisor32, 2 kernel32, 3 64-bit) |
| us_i | input | 1 | 1 = unsigned operation, 0 = signed operation |
| sat_i | input | 1 | 1 = saturate the result |
| hi_i | input | 1 | Selects the high result register (1) or the low one (0) for `rd_o` |
| rs_i | input | 64 | First source operand |
| rt_i | input | 64 | Second source operand |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rsvd_o | output | 1 | Reserved-operation flag |
| rd_o | output | 64 | Destination write data |
| hi_o | output | 64 | High result register |
| lo_o | output | 64 | Low result register / accumulator |

## Verification
The assertions check the handshake on every cycle: busy is always followed by done, done and busy are never high together, and a reserved flag never coincides with either. They also check on every cycle that the accumulator changes only in a done cycle, that the high and low registers agree, and that a signed saturating result lies inside the 32-bit range. The exact arithmetic can only be shown by the bench's sweeps, which compare each result against a wide model. These cover signed and unsigned extension of operands and accumulator, wrap without saturation, the exact clamp values on each side, and accumulation onto a value completed in the same cycle. Ignored issues while busy and rejected issues in the illegal modes are likewise checked only by directed scenarios.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MODE_USR32 = 2'd0,
    MODE_SUP32 = 2'd1,
    MODE_KRN32 = 2'd2,
    MODE_W64   = 2'd3
  } cpu_mode_e;

  typedef struct packed {
    logic us;
    logic sat;
    logic hsel;
  } mac_ctl_t;

  function automatic logic mode_legal(cpu_mode_e m);
    return (m == MODE_KRN32) || (m == MODE_W64);
  endfunction
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int OP_W = 32,
  localparam int PW  = 2 * OP_W + 2
) (
  input  logic [OP_W-1:0]       a_i,
  input  logic [OP_W-1:0]       b_i,
  input  logic                  us_i,
  output logic signed [PW-1:0]  prod_o
);
  logic signed [OP_W:0] a_x, b_x;

  // one extra bit carries sign or zero extension
  assign a_x = $signed({us_i ? 1'b0 : a_i[OP_W-1], a_i});
  assign b_x = $signed({us_i ? 1'b0 : b_i[OP_W-1], b_i});

  always_comb begin
    logic signed [PW-1:0] ae, be;
    ae = PW'(a_x);
    be = PW'(b_x);
    prod_o = ae * be;
  end
endmodule

// File: rtl/mac_acc_sat.sv
module mac_acc_sat #(
  parameter int ACC_W = 64,
  parameter int OP_W  = 32,
  parameter int SAT_W = 32,
  localparam int PW   = 2 * OP_W + 2,
  localparam int SW   = ACC_W + 2
) (
  input  logic [ACC_W-1:0]      acc_i,
  input  logic signed [PW-1:0]  prod_i,
  input  logic                  us_i,
  input  logic                  sat_i,
  output logic [ACC_W-1:0]      res_o
);
  localparam logic signed [SW-1:0] S_MAX =
    $signed({{(SW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}});
  localparam logic signed [SW-1:0] S_MIN = ~S_MAX;

  logic signed [SW-1:0] acc_x, prod_x, sum;
  logic                 u_ovf, s_ovf, s_unf;

  assign acc_x  = us_i ? $signed({2'b00, acc_i})
                       : $signed({{2{acc_i[ACC_W-1]}}, acc_i});
  assign prod_x = SW'(prod_i);
  assign sum    = acc_x + prod_x;

  assign u_ovf = |sum[SW-1:ACC_W];
  assign s_ovf = sum > S_MAX;
  assign s_unf = sum < S_MIN;

  always_comb begin
    res_o = sum[ACC_W-1:0];
    if (sat_i) begin
      if (us_i) begin
        if (u_ovf) res_o = '1;
      end else if (s_ovf) begin
        res_o = S_MAX[ACC_W-1:0];
      end else if (s_unf) begin
        res_o = S_MIN[ACC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic legal_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o,
  output logic rsvd_o
);
  assign accept_o = start_i && !busy_o && legal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      rsvd_o <= 1'b0;
    end else begin
      busy_o <= accept_o;
      done_o <= busy_o;
      rsvd_o <= start_i && !busy_o && !legal_i;
    end
  end

  // R8
  busy_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> done_o);
  // R8
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  rsvd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> (!busy_o && !done_o));
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int OP_W  = 32,
  parameter int SAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             us_i,
  input  logic             sat_i,
  input  logic             hi_i,
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] rt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             rsvd_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int PW = 2 * OP_W + 2;
  localparam logic [REG_W-1:0] S_MAX_L = {{(REG_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [REG_W-1:0] S_MIN_L = ~S_MAX_L;

  logic                 accept, legal;
  logic signed [PW-1:0] prod_d, prod_q;
  mac_ctl_t             ctl_q;
  logic [REG_W-1:0]     acc_res, lo_new, hi_new;
  logic [REG_W-1:0]     lo_q, hi_q, rd_q;

  assign legal = mode_legal(cpu_mode_e'(mode_i));

  mac_mul #(.OP_W(OP_W)) u_mul (
    .a_i    (rs_i[OP_W-1:0]),
    .b_i    (rt_i[OP_W-1:0]),
    .us_i   (us_i),
    .prod_o (prod_d)
  );

  mac_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .legal_i  (legal),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rsvd_o   (rsvd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      ctl_q  <= '0;
    end else if (accept) begin
      prod_q <= prod_d;
      ctl_q  <= '{us: us_i, sat: sat_i, hsel: hi_i};
    end
  end

  mac_acc_sat #(.ACC_W(REG_W), .OP_W(OP_W), .SAT_W(SAT_W)) u_acc (
    .acc_i  (lo_q),
    .prod_i (prod_q),
    .us_i   (ctl_q.us),
    .sat_i  (ctl_q.sat),
    .res_o  (acc_res)
  );

  assign lo_new = acc_res;
  assign hi_new = acc_res;

  // write-back in the busy cycle; done pulses alongside the new values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      rd_q <= '0;
    end else if (busy_o) begin
      lo_q <= lo_new;
      hi_q <= hi_new;
      rd_q <= ctl_q.hsel ? hi_new : lo_new;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
  assign rd_o = rd_q;

  // R7
  lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (lo_o == $past(lo_o) && rd_o == $past(rd_o)));
  // R2
  hi_lo_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hi_o == lo_o && rd_o == lo_o));
  // R4
  s_sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ctl_q.sat && !ctl_q.us) |->
      ($signed(lo_o) <= $signed(S_MAX_L) && $signed(lo_o) >= $signed(S_MIN_L)));
endmodule

// File: tb/sim_mac_sat_unit.sv
module sim_mac_sat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd3;
  logic        us = 1'b0, sat = 1'b0, hsel = 1'b0;
  logic [63:0] rs = '0, rt = '0;
  logic        busy, done, rsvd;
  logic [63:0] rd, hi, lo;

  int nvec = 0;
  int nbad = 0;
  logic [63:0] lo_m = '0;

  always #5 clk = ~clk;

  mac_sat_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .us_i(us), .sat_i(sat), .hi_i(hsel), .rs_i(rs), .rt_i(rt),
    .busy_o(busy), .done_o(done), .rsvd_o(rsvd),
    .rd_o(rd), .hi_o(hi), .lo_o(lo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] acc, input logic [31:0] a,
                                        input logic [31:0] b, input logic u, input logic s);
    logic signed [129:0] av, bv, cv, sm;
    av = u ? $signed({98'd0, a}) : $signed({{98{a[31]}}, a});
    bv = u ? $signed({98'd0, b}) : $signed({{98{b[31]}}, b});
    cv = u ? $signed({66'd0, acc}) : $signed({{66{acc[63]}}, acc});
    sm = cv + av * bv;
    if (s && u && sm > $signed({66'd0, {64{1'b1}}})) return '1;
    if (s && !u && sm > 130'sd2147483647) return 64'h0000_0000_7FFF_FFFF;
    if (s && !u && sm < -130'sd2147483648) return 64'hFFFF_FFFF_8000_0000;
    return sm[63:0];
  endfunction

  // drive at negedge, leave checks at the done negedge (start left low)
  task automatic op(input string req, input logic u, input logic s, input logic h,
                    input logic [63:0] a, input logic [63:0] b);
    start = 1'b1; mode = 2'd3; us = u; sat = s; hsel = h; rs = a; rt = b;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check({req, " R8 busy"}, {63'd0, busy}, 64'd1);
    check({req, " R8 no early done"}, {63'd0, done}, 64'd0);
    @(posedge clk); @(negedge clk);
    lo_m = model(lo_m, a[31:0], b[31:0], u, s);
    check({req, " R8 done"}, {63'd0, done}, 64'd1);
    check({req, " lo"}, lo, lo_m);
    check({req, " R2 hi"}, hi, lo_m);
    check({req, " R2 rd"}, rd, lo_m);
  endtask

  logic [63:0] pats [8] = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF,
                            64'h1234_5678_8000_0000, 64'hAAAA_AAAA_FFFF_FFFF,
                            64'h0000_0000_0001_E240, 64'hDEAD_BEEF_FFFF_FFF7};

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R10
    check("R10 lo", lo, 64'd0);
    check("R10 hi", hi, 64'd0);
    check("R10 rd", rd, 64'd0);
    check("R10 flags", {61'd0, busy, done, rsvd}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R9 sweep; issues run back to back (start in the done cycle)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 4; k++)
          op("R1 R9 sweep", k[0], k[1], i[0] ^ j[0], pats[i], pats[j]);

    // R4 signed overflow: bring into range, then +2^62
    op("R4 prep", 1'b0, 1'b1, 1'b0, 64'd0, 64'd0);
    op("R4", 1'b0, 1'b1, 1'b1, 64'h8000_0000, 64'h8000_0000);
    check("R4 clamp", lo, 64'h0000_0000_7FFF_FFFF);
    // R5 signed underflow
    op("R5", 1'b0, 1'b1, 1'b0, 64'h8000_0000, 64'h7FFF_FFFF);
    check("R5 clamp", lo, 64'hFFFF_FFFF_8000_0000);
    // R1 upper bits ignored, signed accumulate from -2^31
    op("R1 upper", 1'b0, 1'b0, 1'b0, 64'hFFFF_0000_0000_0002, 64'h7777_7777_0000_0003);
    check("R1 upper", lo, 64'hFFFF_FFFF_8000_0006);
    // R6 unsigned overflow
    op("R6 a", 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    op("R6 b", 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    check("R6 clamp", lo, 64'hFFFF_FFFF_FFFF_FFFF);
    // R3 wrap without saturation
    op("R3", 1'b1, 1'b0, 1'b0, 64'd1, 64'd1);
    check("R3 wrap", lo, 64'd0);

    // R7 illegal modes
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      start = 1'b1; mode = 2'(m); us = 1'b1; sat = 1'b0; rs = 64'd5; rt = 64'd7;
      @(posedge clk); @(negedge clk);
      start = 1'b0; mode = 2'd3;
      check("R7 rsvd", {63'd0, rsvd}, 64'd1);
      check("R7 no busy", {63'd0, busy}, 64'd0);
      @(posedge clk); @(negedge clk);
      check("R7 rsvd drops", {63'd0, rsvd}, 64'd0);
      check("R7 no done", {63'd0, done}, 64'd0);
      check("R7 lo kept", lo, lo_m);
      check("R7 hi kept", hi, lo_m);
      check("R7 rd kept", rd, lo_m);
    end

    // R8 start while busy ignored
    start = 1'b1; us = 1'b1; sat = 1'b0; hsel = 1'b0; rs = 64'd3; rt = 64'd4;
    @(posedge clk); @(negedge clk);
    rs = 64'd100; rt = 64'd100;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lo_m = model(lo_m, 32'd3, 32'd4, 1'b1, 1'b0);
    check("R8 ignore result", lo, lo_m);
    @(posedge clk); @(negedge clk);
    check("R8 ignore no busy", {63'd0, busy}, 64'd0);
    @(posedge clk); @(negedge clk);
    check("R8 ignore no done", {63'd0, done}, 64'd0);
    check("R8 ignore lo", lo, lo_m);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule